// File: doc/BRIEF.md
# SD Long Response Receiver

This block receives the 136-bit long response that a memory card returns on its command line after a request for its identification or specific-data register. Software arms the receiver with a one-cycle arm request and gives it a destination word address. The receiver then watches the serially sampled command line for the start bit and shifts in the whole frame. It checks the 7-bit CRC that covers the payload and hands the 128 bits that follow the reserved field to a local buffer as four 32-bit words through a simple write port.

The receiver sets a busy flag when it is armed. The flag clears by itself when the end bit has been taken in, or when no start bit shows up within a fixed number of sampled bit periods. Sticky status flags report completion, a CRC mismatch, a bad end bit and a timeout. The completion flag is cleared by a write-1 pulse. The error flags are cleared when the receiver is armed again.

The controller is a three-state machine. IDLE goes to HUNT on an arm request. HUNT goes to CAPTURE on the first sampled 0, or back to IDLE on timeout. CAPTURE goes back to IDLE on the end bit. The CRC engine, the word packer and the status logic follow strobes that the controller decodes from its bit index.

Top module: `sd_r2_rx`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `crc_err_o`, `frame_err_o`, `timeout_o` and `wr_en_o` are all 0.
- R2: An `arm_req` pulse while idle sets `busy_o`, latches `base_addr` and clears `crc_err_o`, `frame_err_o` and `timeout_o`. An `arm_req` while busy is ignored, and the latched address stays in use.
- R3: The line is sampled only in cycles with `cmd_vld` high. While idle, sampled values are ignored. While hunting, the first sampled 0 is taken as bit 0 of the frame.
- R4: The frame is 136 sampled bits, in this order: bit 0 start (0), bit 1 direction (0), bits 2..7 reserved, bits 8..127 content, bits 128..134 CRC with MSB first, bit 135 end. One cycle after the end bit is sampled, `busy_o` is 0 and `done_o` is 1.
- R5: Frame bits 8..135 are packed MSB first into four 32-bit words. Word k holds bits 8+32k..39+32k, with the first of these in bit 31. Word k is written to address base+k with a one-cycle `wr_en_o` pulse, one cycle after its last bit is sampled.
- R6: The CRC is computed over the 120 content bits, MSB first, with polynomial x^7+x^3+1 and a zero start value. `crc_err_o` is 1 after the end bit exactly when this CRC differs from the received bits 128..134.
- R7: `frame_err_o` is 1 after the end bit exactly when the sampled end bit is 0.
- R8: If the first 64 samples after arming are all 1, `timeout_o` is set one cycle after the 64th sample. `busy_o` clears at the same time, no word is written and `done_o` is unchanged. A 0 at the 64th sample is still accepted as a start bit.
- R9: A `done_clr` pulse clears `done_o` on the next cycle. If completion happens in the same cycle as the pulse, the completion wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_req | input | 1 | One-cycle arm request (sets the enable) |
| base_addr | input | ADDR_W | Destination word address, latched on arm |
| cmd_vld | input | 1 | Sample strobe for the command line |
| cmd_bit | input | 1 | Command line value |
| done_clr | input | 1 | Write-1 clear of the completion flag |
| busy_o | output | 1 | Enable bit, clears itself when the receiver finishes |
| done_o | output | 1 | Response-complete flag |
| crc_err_o | output | 1 | CRC mismatch flag |
| frame_err_o | output | 1 | End bit was 0 |
| timeout_o | output | 1 | No start bit within the timeout window |
| wr_en_o | output | 1 | Buffer write strobe |
| wr_addr_o | output | ADDR_W | Buffer word address |
| wr_data_o | output | 32 | Buffer write data |

## Verification
Every result lands exactly one clock after the sample that causes it. Each word write follows the sample of bits 39, 71, 103 and 135. The status flags and the cleared busy flag follow the end bit or the 64th idle sample. `done_o` falls one clock after `done_clr`. The bench drives one sample per strobe on the falling edge. It reads the outputs on the falling edge after that strobe's rising edge, when all these results have settled. Between strobes, `cmd_vld` is held low and the bench drives the inverted bit, so a sample taken at the wrong time would corrupt the data. The scoreboard matches every write as it appears and flags any write it does not expect.

// File: rtl/sd_r2_pkg.sv
package sd_r2_pkg;
    localparam int FRAME_BITS   = 136;
    localparam int CONT_FIRST   = 8;
    localparam int CONT_LAST    = 127;
    localparam int CRC_FIRST    = 128;
    localparam int CRC_LAST     = 134;
    localparam int END_IDX      = FRAME_BITS - 1;
    localparam int IDX_W        = $clog2(FRAME_BITS);
    localparam int WORD_W       = 32;
    localparam int NUM_WORDS    = (FRAME_BITS - CONT_FIRST) / WORD_W;
    localparam int CRC_W        = 7;
    localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HUNT    = 2'd1,
        ST_CAPTURE = 2'd2
    } r2_state_e;
endpackage

// File: rtl/sd_r2_crc7.sv
module sd_r2_crc7
    import sd_r2_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic calc_en,
    input  logic cap_en,
    input  logic bit_i,
    output logic match_o
);
    logic [CRC_W-1:0] rem_q, rem_d, rx_q;
    logic             fb;

    always_comb begin
        fb    = rem_q[CRC_W-1] ^ bit_i;
        rem_d = {rem_q[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & CRC_POLY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            rx_q  <= '0;
        end else if (clr) begin
            rem_q <= '0;
            rx_q  <= '0;
        end else begin
            if (calc_en) rem_q <= rem_d;
            if (cap_en)  rx_q  <= {rx_q[CRC_W-2:0], bit_i};
        end
    end

    assign match_o = (rem_q == rx_q);

    // R6: the payload remainder and the received field never update together
    p_calc_cap_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(calc_en && cap_en));
endmodule

// File: rtl/sd_r2_packer.sv
module sd_r2_packer #(
    parameter int ADDR_W = 8,
    parameter int WW     = 32,
    parameter int NW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              bit_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [WW-1:0]     wr_data_o
);
    localparam int CNT_W = $clog2(WW);
    localparam int WIX_W = (NW > 1) ? $clog2(NW) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WW - 1);

    logic [WW-1:0]    sh_q;
    logic [CNT_W-1:0] cnt_q;
    logic [WIX_W-1:0] wix_q;
    logic [WW-1:0]    sh_d;

    assign sh_d = {sh_q[WW-2:0], bit_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q      <= '0;
            cnt_q     <= '0;
            wix_q     <= '0;
            wr_en_o   <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
        end else begin
            wr_en_o <= 1'b0;
            if (clr) begin
                cnt_q <= '0;
                wix_q <= '0;
            end else if (shift_en) begin
                sh_q  <= sh_d;
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CNT_LAST) begin
                    wr_en_o   <= 1'b1;
                    wr_data_o <= sh_d;
                    wr_addr_o <= base_i + ADDR_W'(wix_q);
                    wix_q     <= wix_q + 1'b1;
                end
            end
        end
    end

    // R5: each word is written with a single-cycle strobe
    p_single_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);
endmodule

// File: rtl/sd_r2_ctrl.sv
module sd_r2_ctrl
    import sd_r2_pkg::*;
#(
    parameter int TIMEOUT_BITS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_req,
    input  logic cmd_vld,
    input  logic cmd_bit,
    input  logic done_clr,
    input  logic crc_match_i,
    output logic busy_o,
    output logic done_o,
    output logic crc_err_o,
    output logic frame_err_o,
    output logic timeout_o,
    output logic seq_clr_o,
    output logic crc_calc_o,
    output logic crc_cap_o,
    output logic pack_o
);
    localparam int TO_W = (TIMEOUT_BITS > 1) ? $clog2(TIMEOUT_BITS) : 1;
    localparam logic [TO_W-1:0]  TO_LAST    = TO_W'(TIMEOUT_BITS - 1);
    localparam logic [IDX_W-1:0] I_CONT_LO  = IDX_W'(CONT_FIRST);
    localparam logic [IDX_W-1:0] I_CONT_HI  = IDX_W'(CONT_LAST);
    localparam logic [IDX_W-1:0] I_CRC_LO   = IDX_W'(CRC_FIRST);
    localparam logic [IDX_W-1:0] I_CRC_HI   = IDX_W'(CRC_LAST);
    localparam logic [IDX_W-1:0] I_END      = IDX_W'(END_IDX);

    r2_state_e        state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [TO_W-1:0]  to_q;
    logic             done_q, crc_err_q, frame_err_q, timeout_q;
    logic             rx_tick, start_seen, finish, timeout_hit;

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (arm_req) state_d = ST_HUNT;
            ST_HUNT:    if (start_seen) state_d = ST_CAPTURE;
                        else if (timeout_hit) state_d = ST_IDLE;
            ST_CAPTURE: if (finish) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register and sequencing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            to_q    <= '0;
        end else begin
            state_q <= state_d;
            if (seq_clr_o) to_q <= '0;
            else if (state_q == ST_HUNT && cmd_vld) to_q <= to_q + 1'b1;
            if (start_seen) idx_q <= IDX_W'(1);
            else if (rx_tick) idx_q <= idx_q + 1'b1;
        end
    end

    // output decode process
    always_comb begin
        seq_clr_o   = 1'b0;
        start_seen  = 1'b0;
        timeout_hit = 1'b0;
        rx_tick     = 1'b0;
        unique case (state_q)
            ST_IDLE:    seq_clr_o = arm_req;
            ST_HUNT: begin
                start_seen  = cmd_vld && !cmd_bit;
                timeout_hit = cmd_vld && cmd_bit && (to_q == TO_LAST);
            end
            ST_CAPTURE: rx_tick = cmd_vld;
            default: ;
        endcase
        crc_calc_o = rx_tick && (idx_q >= I_CONT_LO) && (idx_q <= I_CONT_HI);
        crc_cap_o  = rx_tick && (idx_q >= I_CRC_LO) && (idx_q <= I_CRC_HI);
        pack_o     = rx_tick && (idx_q >= I_CONT_LO);
        finish     = rx_tick && (idx_q == I_END);
    end

    // status register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q      <= 1'b0;
            crc_err_q   <= 1'b0;
            frame_err_q <= 1'b0;
            timeout_q   <= 1'b0;
        end else begin
            if (finish) done_q <= 1'b1;
            else if (done_clr) done_q <= 1'b0;
            if (seq_clr_o) begin
                crc_err_q   <= 1'b0;
                frame_err_q <= 1'b0;
                timeout_q   <= 1'b0;
            end
            if (finish) begin
                crc_err_q   <= !crc_match_i;
                frame_err_q <= !cmd_bit;
            end
            if (timeout_hit) timeout_q <= 1'b1;
        end
    end

    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = done_q;
    assign crc_err_o   = crc_err_q;
    assign frame_err_o = frame_err_q;
    assign timeout_o   = timeout_q;

    // R2: arming from idle makes the receiver busy with a clean timeout flag
    p_arm_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && arm_req) |=> (busy_o && !timeout_o));
    // R4: the enable only drops on completion or timeout
    p_busy_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (done_o || timeout_o));
    // R6: a CRC error only appears alongside completion
    p_crc_err_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_err_o) |-> done_o);
    // R7: a framing error only appears alongside completion
    p_frame_err_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err_o) |-> done_o);
    // R8: a timeout leaves the receiver idle
    p_timeout_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> !busy_o);
    // R9: a clear without a completion drops the done flag
    p_done_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && done_clr && !finish) |=> !done_o);
endmodule

// File: rtl/sd_r2_rx.sv
module sd_r2_rx
    import sd_r2_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int TIMEOUT_BITS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_req,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              cmd_vld,
    input  logic              cmd_bit,
    input  logic              done_clr,
    output logic              busy_o,
    output logic              done_o,
    output logic              crc_err_o,
    output logic              frame_err_o,
    output logic              timeout_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [WORD_W-1:0] wr_data_o
);
    logic              seq_clr, crc_calc, crc_cap, pack, crc_match;
    logic [ADDR_W-1:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) base_q <= '0;
        else if (seq_clr) base_q <= base_addr;
    end

    sd_r2_ctrl #(.TIMEOUT_BITS(TIMEOUT_BITS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_req     (arm_req),
        .cmd_vld     (cmd_vld),
        .cmd_bit     (cmd_bit),
        .done_clr    (done_clr),
        .crc_match_i (crc_match),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .crc_err_o   (crc_err_o),
        .frame_err_o (frame_err_o),
        .timeout_o   (timeout_o),
        .seq_clr_o   (seq_clr),
        .crc_calc_o  (crc_calc),
        .crc_cap_o   (crc_cap),
        .pack_o      (pack)
    );

    sd_r2_crc7 u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (seq_clr),
        .calc_en (crc_calc),
        .cap_en  (crc_cap),
        .bit_i   (cmd_bit),
        .match_o (crc_match)
    );

    sd_r2_packer #(.ADDR_W(ADDR_W), .WW(WORD_W), .NW(NUM_WORDS)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (seq_clr),
        .shift_en  (pack),
        .bit_i     (cmd_bit),
        .base_i    (base_q),
        .wr_en_o   (wr_en_o),
        .wr_addr_o (wr_addr_o),
        .wr_data_o (wr_data_o)
    );

    // R5: every write lands inside the four-word window above the latched base
    p_addr_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> ((wr_addr_o - base_q) < ADDR_W'(NUM_WORDS)));
    // R3: writes only follow a sample taken while receiving
    p_write_needs_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> $past(busy_o));
endmodule

// File: tb/sd_r2_rx_test.sv
module sd_r2_rx_test;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm_req = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic          cmd_vld = 1'b0;
    logic          cmd_bit = 1'b1;
    logic          done_clr = 1'b0;
    logic          busy_o, done_o, crc_err_o, frame_err_o, timeout_o, wr_en_o;
    logic [AW-1:0] wr_addr_o;
    logic [31:0]   wr_data_o;

    int checks = 0;
    int errors = 0;
    logic [AW+31:0] exp_q[$];

    always #10 clk = ~clk;

    sd_r2_rx #(.ADDR_W(AW), .TIMEOUT_BITS(64)) uut (
        .clk(clk), .rst_n(rst_n), .arm_req(arm_req), .base_addr(base_addr),
        .cmd_vld(cmd_vld), .cmd_bit(cmd_bit), .done_clr(done_clr),
        .busy_o(busy_o), .done_o(done_o), .crc_err_o(crc_err_o),
        .frame_err_o(frame_err_o), .timeout_o(timeout_o), .wr_en_o(wr_en_o),
        .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] ref_crc(input logic [119:0] c);
        logic [6:0] r = '0;
        for (int i = 119; i >= 0; i--) begin
            logic top;
            top = r[6] ^ c[i];
            r = {r[5:0], 1'b0};
            if (top) r = r ^ 7'b0001001;
        end
        return r;
    endfunction

    function automatic logic [135:0] mk_frame(input logic [119:0] c, input logic [6:0] crc,
                                              input logic endb);
        return {2'b00, 6'b111111, c, crc, endb};
    endfunction

    // scoreboard driver side: queue the four expected words
    task automatic push_words(input logic [AW-1:0] base, input logic [135:0] f);
        for (int k = 0; k < 4; k++)
            exp_q.push_back({base + AW'(k), f[127 - 32*k -: 32]});
    endtask

    // monitor: pops and compares each write as it appears (R5)
    always @(negedge clk) begin
        if (rst_n && wr_en_o) begin
            if (exp_q.size() == 0) begin
                chk("R5 unexpected write", {24'd0, wr_addr_o, wr_data_o}, 64'd0);
            end else begin
                logic [AW+31:0] e;
                e = exp_q.pop_front();
                chk("R5 write addr/data", {24'd0, wr_addr_o, wr_data_o}, {24'd0, e});
            end
        end
    end

    task automatic arm(input logic [AW-1:0] base);
        @(negedge clk);
        arm_req   = 1'b1;
        base_addr = base;
        @(negedge clk);
        arm_req   = 1'b0;
    endtask

    task automatic send_bit(input logic b, input logic clr_now);
        @(negedge clk);
        cmd_vld  = 1'b1;
        cmd_bit  = b;
        done_clr = clr_now;
        @(negedge clk);
        cmd_vld  = 1'b0;
        cmd_bit  = ~b;
        done_clr = 1'b0;
    endtask

    task automatic send_frame(input logic [135:0] f, input logic clr_last);
        for (int i = 135; i >= 0; i--) send_bit(f[i], clr_last && (i == 0));
        @(negedge clk);
    endtask

    task automatic drain(input string req);
        @(negedge clk);
        chk(req, 64'(exp_q.size()), 64'd0);
        exp_q.delete();
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [119:0] c1, c2, c3;
        logic [6:0]   k1, k2, k3;
        logic [135:0] f;
        c1 = {24'h123456, 32'hDEADBEEF, 32'h0F1E2D3C, 32'hA5A55A5A};
        c2 = {24'hFEDCBA, 32'h00000001, 32'h80000000, 32'h13579BDF};
        c3 = {24'h000000, 32'hCAFEF00D, 32'h76543210, 32'hFFFFFFFF};
        k1 = ref_crc(c1);
        k2 = ref_crc(c2);
        k3 = ref_crc(c3);

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", 64'(busy_o), 0);
        chk("R1 status", 64'({done_o, crc_err_o, frame_err_o, timeout_o}), 0);
        chk("R1 wr_en", 64'(wr_en_o), 0);
        rst_n = 1'b1;

        // R3: samples while idle are ignored
        for (int i = 0; i < 10; i++) send_bit(1'b0, 1'b0);
        chk("R3 idle zeros ignored busy", 64'(busy_o), 0);
        chk("R3 idle zeros ignored done", 64'(done_o), 0);

        // R2, R4, R5, R6: clean frame
        arm(8'h10);
        chk("R2 busy after arm", 64'(busy_o), 1);
        f = mk_frame(c1, k1, 1'b1);
        push_words(8'h10, f);
        send_frame(f, 1'b0);
        chk("R4 busy cleared", 64'(busy_o), 0);
        chk("R4 done set", 64'(done_o), 1);
        chk("R6 crc ok", 64'(crc_err_o), 0);
        chk("R7 end ok", 64'(frame_err_o), 0);
        drain("R5 all words written");

        // R9: write-1 clear
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
        chk("R9 done cleared", 64'(done_o), 0);

        // R6: corrupted CRC
        arm(8'h20);
        f = mk_frame(c2, k2 ^ 7'h04, 1'b1);
        push_words(8'h20, f);
        send_frame(f, 1'b0);
        chk("R6 crc error", 64'(crc_err_o), 1);
        chk("R6 done with crc error", 64'(done_o), 1);
        chk("R7 end ok with bad crc", 64'(frame_err_o), 0);
        drain("R5 words with bad crc");

        // R7 and R2 flag clearing: bad end bit; R9 set wins over clear
        arm(8'hFE);
        chk("R2 crc flag cleared on arm", 64'(crc_err_o), 0);
        f = mk_frame(c3, k3, 1'b0);
        push_words(8'hFE, f);
        send_frame(f, 1'b1);
        chk("R7 framing error", 64'(frame_err_o), 1);
        chk("R6 crc ok on bad end", 64'(crc_err_o), 0);
        chk("R9 completion wins over clear", 64'(done_o), 1);
        drain("R5 words wrap address");
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;

        // R8: timeout after 64 idle samples
        arm(8'h40);
        for (int i = 0; i < 63; i++) send_bit(1'b1, 1'b0);
        chk("R8 still busy at 63", 64'(busy_o), 1);
        send_bit(1'b1, 1'b0);
        chk("R8 timeout set", 64'(timeout_o), 1);
        chk("R8 busy cleared", 64'(busy_o), 0);
        chk("R8 done unchanged", 64'(done_o), 0);
        for (int i = 0; i < 20; i++) send_bit(1'b0, 1'b0);
        drain("R8 no writes");

        // R8 boundary: start bit on the 64th sample is accepted
        arm(8'h50);
        chk("R2 timeout flag cleared on arm", 64'(timeout_o), 0);
        for (int i = 0; i < 63; i++) send_bit(1'b1, 1'b0);
        f = mk_frame(c1, k1, 1'b1);
        push_words(8'h50, f);
        send_frame(f, 1'b0);
        chk("R8 late start accepted", 64'(done_o), 1);
        chk("R8 no timeout on late start", 64'(timeout_o), 0);
        drain("R8 late start words");
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;

        // R2: arm while busy is ignored
        arm(8'h60);
        send_bit(1'b1, 1'b0);
        arm(8'h90);
        f = mk_frame(c2, k2, 1'b1);
        push_words(8'h60, f);
        send_frame(f, 1'b0);
        chk("R2 busy cleared after frame", 64'(busy_o), 0);
        chk("R2 crc ok", 64'(crc_err_o), 0);
        drain("R2 second arm ignored");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule